// File: doc/BRIEF.md
# Host Window into Controller Memory and Mailboxes

This block is a small register window that a host bus sees as sixteen byte-wide I/O offsets. Through it the host reaches the private word memory of an embedded controller indirectly: it loads an address register whose two low bits pick an access width, then reads and writes a four-byte data window that turns into byte, halfword or word accesses to the memory. One of the word modes steps the address forward after each full word, so a burst needs only one address setup.

Beside the memory path the window has two 8-bit mailboxes: one carries messages from the host to the controller and one carries them back. It also has a 16-bit interrupt source register that the host clears by writing ones, and a 16-bit mask that gates the host interrupt line. A simple controller-side port posts messages into the return mailbox and raises source bits.

Halfword and word writes are gathered in a holding register and reach the memory together, on the write of the highest byte of the unit. A word read latches the whole word when byte 0 is read, so the later bytes come from one coherent copy.

Top module: `emi_window`

## Requirements
- R1: After reset every offset reads 0x00, the memory holds zeros, `host_irq` is low and `ctl_h2c_mbox` is 0x00.
- R2: Offset 0x0 is the host-to-controller mailbox. The host can write it and read it back, and its value is driven on `ctl_h2c_mbox`.
- R3: A controller post (`ctl_mbox_we` high) loads `ctl_mbox_data` into the return mailbox at offset 0x1 and sets interrupt source bit 0.
- R4: A host write to offset 0x1 with the value the mailbox holds clears the mailbox to 0x00. A host write of any other value stores that value.
- R5: The interrupt source register sits at 0x8 (bits 7:0) and 0x9 (bits 15:8). Writing a 1 to a bit clears it and writing a 0 leaves it unchanged. Bits set by `ctl_irq_set` are ORed in, and a set wins over a clear in the same cycle.
- R6: The interrupt mask sits at 0xA (bits 7:0) and 0xB (bits 15:8), and each byte is read/write on its own. `host_irq` is high exactly while (source AND mask) is non-zero, so an all-zero mask holds it low.
- R7: The address register sits at 0x2 (bits 7:0) and 0x3 (bits 15:8). A write changes only the addressed byte, and both bytes read back. Bits 1:0 hold the mode: 0 = byte, 1 = halfword, 2 = word, 3 = word with auto-increment.
- R8: The addressed memory word is address bits 15:2 modulo the memory depth. Window byte 0x4+k maps to memory byte k of that word, with byte 0 in bits 7:0.
- R9: In byte mode, a write to window byte k updates memory byte k at once, and a read of window byte k returns memory byte k directly.
- R10: In halfword mode, a write to an even window byte (0x4, 0x6) is held and leaves the memory unchanged. A write to the following odd byte (0x5, 0x7) writes both bytes of that halfword. Reads come directly from memory.
- R11: In the two word modes, writes to 0x4..0x6 are held and a write to 0x7 writes all four bytes. A read of 0x4 returns memory byte 0 and latches the whole word; reads of 0x5..0x7 return bytes 1..3 of the latched word.
- R12: In mode 3, any read or write of offset 0x7 adds 4 to the address, wrapping at 16 bits and keeping the mode bits. In other modes data window accesses never change the address.
- R13: Offsets 0xC..0xF read 0x00, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Host access strobe, one access per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_ofs | input | 4 | Byte offset within the window |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte for the current offset (combinational) |
| host_irq | output | 1 | Host interrupt, high while a source bit is unmasked |
| ctl_mbox_we | input | 1 | Controller posts a message to the return mailbox |
| ctl_mbox_data | input | 8 | Message posted by the controller |
| ctl_irq_set | input | 16 | Controller pulse that sets interrupt source bits |
| ctl_h2c_mbox | output | 8 | Current host-to-controller mailbox value |

## Verification
The bench builds the block with MEM_WORDS = 16, so the memory index wraps after sixteen words. An auto-increment burst can then run off the last word onto word 0 in a few accesses. The 16-bit address rollover from 0xFFFF is reached directly by loading the address register. With the small depth, every mode, the held-write and latched-read behaviour, and both wrap points fit in a short sequence of byte accesses.

// File: rtl/emi_pkg.sv
package emi_pkg;

  typedef enum logic [1:0] {
    MODE_B8      = 2'd0,
    MODE_H16     = 2'd1,
    MODE_W32     = 2'd2,
    MODE_W32_INC = 2'd3
  } emi_mode_e;

  localparam logic [3:0] OFS_H2C     = 4'h0;
  localparam logic [3:0] OFS_C2H     = 4'h1;
  localparam logic [3:0] OFS_ADDR_LO = 4'h2;
  localparam logic [3:0] OFS_ADDR_HI = 4'h3;
  localparam logic [3:0] OFS_SRC_LO  = 4'h8;
  localparam logic [3:0] OFS_SRC_HI  = 4'h9;
  localparam logic [3:0] OFS_MSK_LO  = 4'hA;
  localparam logic [3:0] OFS_MSK_HI  = 4'hB;

  // Byte lanes of the memory word written when window lane `lane` is written.
  function automatic logic [3:0] commit_lanes(emi_mode_e mode, logic [1:0] lane);
    logic [3:0] m;
    m = 4'b0000;
    case (mode)
      MODE_B8:  m = 4'b0001 << lane;
      MODE_H16: m = lane[0] ? (lane[1] ? 4'b1100 : 4'b0011) : 4'b0000;
      default:  m = (lane == 2'd3) ? 4'b1111 : 4'b0000;
    endcase
    return m;
  endfunction

  // Next address after an auto-increment step; mode bits are kept.
  function automatic logic [15:0] step_addr(logic [15:0] a);
    return {a[15:2] + 14'd1, a[1:0]};
  endfunction

  // Write-one-to-clear update with a set that wins.
  function automatic logic [15:0] w1c_update(logic [15:0] cur, logic [15:0] clr,
                                             logic [15:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/emi_regs.sv
module emi_regs
  import emi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  ofs,
  input  logic [7:0]  wdata,
  input  logic        ctl_mbox_we,
  input  logic [7:0]  ctl_mbox_data,
  input  logic [15:0] ctl_irq_set,
  output logic [7:0]  h2c_q,
  output logic [7:0]  c2h_q,
  output logic [15:0] src_q,
  output logic [15:0] mask_q,
  output logic        irq
);

  logic        c2h_clear_ev;
  logic [15:0] src_clr;
  logic [15:0] src_set;

  assign c2h_clear_ev = wr_en && (ofs == OFS_C2H) && (wdata == c2h_q);
  assign src_clr = !wr_en               ? 16'h0000 :
                   (ofs == OFS_SRC_LO)  ? {8'h00, wdata} :
                   (ofs == OFS_SRC_HI)  ? {wdata, 8'h00} : 16'h0000;
  assign src_set = ctl_irq_set | {15'h0000, ctl_mbox_we};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h2c_q  <= '0;
      c2h_q  <= '0;
      src_q  <= '0;
      mask_q <= '0;
    end else begin
      if (wr_en && ofs == OFS_H2C) h2c_q <= wdata;
      if (ctl_mbox_we)                       c2h_q <= ctl_mbox_data;
      else if (c2h_clear_ev)                 c2h_q <= '0;
      else if (wr_en && ofs == OFS_C2H)      c2h_q <= wdata;
      src_q <= w1c_update(src_q, src_clr, src_set);
      if (wr_en && ofs == OFS_MSK_LO) mask_q[7:0]  <= wdata;
      if (wr_en && ofs == OFS_MSK_HI) mask_q[15:8] <= wdata;
    end
  end

  assign irq = |(src_q & mask_q);

endmodule

// File: rtl/emi_mem_port.sv
module emi_mem_port
  import emi_pkg::*;
#(
  parameter int MEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_en,
  input  logic        acc_we,
  input  logic [1:0]  lane,
  input  logic [7:0]  wdata,
  input  logic        addr_wr_lo,
  input  logic        addr_wr_hi,
  output logic [15:0] addr_q,
  output logic [7:0]  rdata,
  output logic        commit_ev,
  output logic        bump_ev
);

  localparam int IDX_W = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1;

  logic [31:0]      mem [MEM_WORDS];
  logic [31:0]      hold_q;
  logic [31:0]      snap_q;
  logic [31:0]      merged;
  logic [31:0]      cur_word;
  logic [3:0]       lanes;
  logic [IDX_W-1:0] idx;
  logic             snap_ev;
  emi_mode_e        mode;

  assign mode     = emi_mode_e'(addr_q[1:0]);
  assign idx      = addr_q[IDX_W+1:2];
  assign cur_word = mem[idx];
  assign lanes    = (acc_en && acc_we) ? commit_lanes(mode, lane) : 4'b0000;
  assign commit_ev = |lanes;
  assign bump_ev  = acc_en && (lane == 2'd3) && (mode == MODE_W32_INC);
  assign snap_ev  = acc_en && !acc_we && (lane == 2'd0) && mode[1];

  always_comb begin
    merged = hold_q;
    merged[lane*8 +: 8] = wdata;
  end

  always_comb begin
    if (mode[1] && lane != 2'd0) rdata = snap_q[lane*8 +: 8];
    else                         rdata = cur_word[lane*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      hold_q <= '0;
      snap_q <= '0;
      for (int w = 0; w < MEM_WORDS; w++) mem[w] <= '0;
    end else begin
      if (addr_wr_lo)   addr_q[7:0]  <= wdata;
      if (addr_wr_hi)   addr_q[15:8] <= wdata;
      if (bump_ev)      addr_q       <= step_addr(addr_q);
      if (acc_en && acc_we) hold_q[lane*8 +: 8] <= wdata;
      if (snap_ev)      snap_q <= cur_word;
      for (int b = 0; b < 4; b++)
        if (lanes[b]) mem[idx][b*8 +: 8] <= merged[b*8 +: 8];
    end
  end

endmodule

// File: rtl/emi_window.sv
module emi_window
  import emi_pkg::*;
#(
  parameter int MEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_cs,
  input  logic        host_we,
  input  logic [3:0]  host_ofs,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        host_irq,
  input  logic        ctl_mbox_we,
  input  logic [7:0]  ctl_mbox_data,
  input  logic [15:0] ctl_irq_set,
  output logic [7:0]  ctl_h2c_mbox
);

  logic        wr_en;
  logic        win_hit;
  logic [7:0]  h2c_q;
  logic [7:0]  c2h_q;
  logic [15:0] src_q;
  logic [15:0] mask_q;
  logic [15:0] addr_q;
  logic [7:0]  win_rdata;
  logic        commit_ev;
  logic        bump_ev;

  assign wr_en   = host_cs && host_we;
  assign win_hit = host_cs && (host_ofs[3:2] == 2'b01);

  emi_regs u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .ofs           (host_ofs),
    .wdata         (host_wdata),
    .ctl_mbox_we   (ctl_mbox_we),
    .ctl_mbox_data (ctl_mbox_data),
    .ctl_irq_set   (ctl_irq_set),
    .h2c_q         (h2c_q),
    .c2h_q         (c2h_q),
    .src_q         (src_q),
    .mask_q        (mask_q),
    .irq           (host_irq)
  );

  emi_mem_port #(.MEM_WORDS(MEM_WORDS)) u_mem (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_en     (win_hit),
    .acc_we     (host_we),
    .lane       (host_ofs[1:0]),
    .wdata      (host_wdata),
    .addr_wr_lo (wr_en && host_ofs == OFS_ADDR_LO),
    .addr_wr_hi (wr_en && host_ofs == OFS_ADDR_HI),
    .addr_q     (addr_q),
    .rdata      (win_rdata),
    .commit_ev  (commit_ev),
    .bump_ev    (bump_ev)
  );

  always_comb begin
    case (host_ofs)
      OFS_H2C:              host_rdata = h2c_q;
      OFS_C2H:              host_rdata = c2h_q;
      OFS_ADDR_LO:          host_rdata = addr_q[7:0];
      OFS_ADDR_HI:          host_rdata = addr_q[15:8];
      4'h4, 4'h5, 4'h6, 4'h7: host_rdata = win_rdata;
      OFS_SRC_LO:           host_rdata = src_q[7:0];
      OFS_SRC_HI:           host_rdata = src_q[15:8];
      OFS_MSK_LO:           host_rdata = mask_q[7:0];
      OFS_MSK_HI:           host_rdata = mask_q[15:8];
      default:              host_rdata = 8'h00;
    endcase
  end

  assign ctl_h2c_mbox = h2c_q;

endmodule

// File: rtl/emi_window_chk.sv
module emi_window_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_cs,
  input logic        host_we,
  input logic [3:0]  host_ofs,
  input logic [7:0]  host_wdata,
  input logic        host_irq,
  input logic        ctl_mbox_we,
  input logic [15:0] ctl_irq_set,
  input logic [7:0]  c2h_q,
  input logic [15:0] src_q,
  input logic [15:0] mask_q,
  input logic [15:0] addr_q,
  input logic        bump_ev,
  input logic        commit_ev
);

  AST_POST_SETS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_mbox_we |=> src_q[0]); // R3

  AST_C2H_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && host_we && host_ofs == 4'h1 && !ctl_mbox_we && host_wdata == c2h_q)
    |=> (c2h_q == 8'h00)); // R4

  AST_SRC_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && host_we && host_ofs == 4'h8 && ctl_irq_set == 16'h0 && !ctl_mbox_we)
    |=> ((src_q[7:0] & $past(host_wdata)) == 8'h00)); // R5

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 16'h0) |-> !host_irq); // R6

  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    bump_ev |=> (addr_q[15:2] == $past(addr_q[15:2]) + 14'd1) && (addr_q[1:0] == 2'b11)); // R12

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && host_ofs[3:2] == 2'b01 && addr_q[1:0] != 2'b11) |=> $stable(addr_q)); // R12

  AST_EVEN_HALF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && host_we && host_ofs[3:2] == 2'b01 && !host_ofs[0] && addr_q[1:0] == 2'b01)
    |-> !commit_ev); // R10

endmodule

bind emi_window emi_window_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_cs     (host_cs),
  .host_we     (host_we),
  .host_ofs    (host_ofs),
  .host_wdata  (host_wdata),
  .host_irq    (host_irq),
  .ctl_mbox_we (ctl_mbox_we),
  .ctl_irq_set (ctl_irq_set),
  .c2h_q       (c2h_q),
  .src_q       (src_q),
  .mask_q      (mask_q),
  .addr_q      (addr_q),
  .bump_ev     (bump_ev),
  .commit_ev   (commit_ev)
);

// File: tb/test_emi_window.sv
module test_emi_window;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_cs = 1'b0;
  logic        host_we = 1'b0;
  logic [3:0]  host_ofs = 4'h0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic        host_irq;
  logic        ctl_mbox_we = 1'b0;
  logic [7:0]  ctl_mbox_data = 8'h00;
  logic [15:0] ctl_irq_set = 16'h0;
  logic [7:0]  ctl_h2c_mbox;

  int vectors = 0;
  int errs = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  emi_window #(.MEM_WORDS(16)) i_emi_window (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_cs       (host_cs),
    .host_we       (host_we),
    .host_ofs      (host_ofs),
    .host_wdata    (host_wdata),
    .host_rdata    (host_rdata),
    .host_irq      (host_irq),
    .ctl_mbox_we   (ctl_mbox_we),
    .ctl_mbox_data (ctl_mbox_data),
    .ctl_irq_set   (ctl_irq_set),
    .ctl_h2c_mbox  (ctl_h2c_mbox)
  );

  // Monitor: pops one expected byte per host read, mid-cycle.
  always @(negedge clk) begin
    if (rst_n && host_cs && !host_we) begin
      vectors++;
      if (sb.size() == 0) begin
        errs++;
        $display("FAIL scoreboard empty: actual %02h expected none", host_rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (host_rdata !== e.exp) begin
          errs++;
          $display("FAIL %s ofs %0h: actual %02h expected %02h", e.tag, host_ofs,
                   host_rdata, e.exp);
        end
      end
    end
  end

  task automatic drive(input logic cs, input logic we, input logic [3:0] ofs,
                       input logic [7:0] wd, input logic mwe, input logic [7:0] md,
                       input logic [15:0] set);
    @(posedge clk);
    #2;
    host_cs = cs; host_we = we; host_ofs = ofs; host_wdata = wd;
    ctl_mbox_we = mwe; ctl_mbox_data = md; ctl_irq_set = set;
  endtask

  task automatic wr(input logic [3:0] ofs, input logic [7:0] d);
    drive(1'b1, 1'b1, ofs, d, 1'b0, 8'h00, 16'h0);
  endtask

  task automatic rd(input logic [3:0] ofs, input logic [7:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    sb.push_back(e);
    drive(1'b1, 1'b0, ofs, 8'h00, 1'b0, 8'h00, 16'h0);
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 4'h0, 8'h00, 1'b0, 8'h00, 16'h0);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", {15'h0, host_irq}, 16'h0);
    chk("R1 h2c port", {8'h0, ctl_h2c_mbox}, 16'h0);
    for (int o = 0; o < 16; o++) rd(o[3:0], 8'h00, "R1");
    // R2 host-to-controller mailbox
    wr(4'h0, 8'h5A); rd(4'h0, 8'h5A, "R2"); idle();
    chk("R2 ctl port", {8'h0, ctl_h2c_mbox}, 16'h005A);
    // R3 controller post
    drive(1'b0, 1'b0, 4'h0, 8'h00, 1'b1, 8'h33, 16'h0);
    rd(4'h1, 8'h33, "R3"); rd(4'h8, 8'h01, "R3"); idle();
    chk("R6 masked irq", {15'h0, host_irq}, 16'h0);
    // R6 mask gates irq
    wr(4'hA, 8'h01); idle();
    chk("R6 unmasked irq", {15'h0, host_irq}, 16'h1);
    wr(4'hA, 8'h00); idle();
    chk("R6 zero mask irq", {15'h0, host_irq}, 16'h0);
    // R4 return mailbox clear
    wr(4'h1, 8'h44); rd(4'h1, 8'h44, "R4");
    wr(4'h1, 8'h44); rd(4'h1, 8'h00, "R4");
    // R5 write-one-to-clear source
    drive(1'b0, 1'b0, 4'h0, 8'h00, 1'b0, 8'h00, 16'h8100);
    rd(4'h8, 8'h01, "R5"); rd(4'h9, 8'h81, "R5");
    wr(4'h9, 8'h80); rd(4'h9, 8'h01, "R5");
    wr(4'h8, 8'h00); rd(4'h8, 8'h01, "R5");
    drive(1'b1, 1'b1, 4'h8, 8'h01, 1'b0, 8'h00, 16'h0001);
    rd(4'h8, 8'h01, "R5 set wins");
    wr(4'h8, 8'h01); rd(4'h8, 8'h00, "R5");
    wr(4'h9, 8'h01); rd(4'h9, 8'h00, "R5");
    // R6 high mask byte
    wr(4'hB, 8'h80); rd(4'hB, 8'h80, "R6"); rd(4'hA, 8'h00, "R6"); idle();
    chk("R6 no source irq", {15'h0, host_irq}, 16'h0);
    drive(1'b0, 1'b0, 4'h0, 8'h00, 1'b0, 8'h00, 16'h8000); idle();
    chk("R6 high source irq", {15'h0, host_irq}, 16'h1);
    wr(4'h9, 8'h80); idle();
    chk("R6 cleared irq", {15'h0, host_irq}, 16'h0);
    // R7 address register bytes
    wr(4'h2, 8'h12); wr(4'h3, 8'h34); rd(4'h2, 8'h12, "R7"); rd(4'h3, 8'h34, "R7");
    wr(4'h3, 8'h00); rd(4'h2, 8'h12, "R7"); rd(4'h3, 8'h00, "R7");
    // R11 word write held until byte 3
    wr(4'h2, 8'h0A);
    wr(4'h4, 8'h11); wr(4'h5, 8'h22); wr(4'h6, 8'h33);
    wr(4'h2, 8'h08); rd(4'h4, 8'h00, "R11 held");
    wr(4'h2, 8'h0A); wr(4'h7, 8'h44);
    wr(4'h2, 8'h08);
    rd(4'h4, 8'h11, "R8"); rd(4'h5, 8'h22, "R8"); rd(4'h6, 8'h33, "R8");
    rd(4'h7, 8'h44, "R8");
    // R9 byte mode
    wr(4'h5, 8'hBB); rd(4'h4, 8'h11, "R9"); rd(4'h5, 8'hBB, "R9");
    rd(4'h6, 8'h33, "R9"); rd(4'h2, 8'h08, "R12 no step");
    // R10 halfword mode on word 3
    wr(4'h2, 8'h0D); wr(4'h6, 8'h66); rd(4'h6, 8'h00, "R10 held");
    wr(4'h7, 8'h77); rd(4'h6, 8'h66, "R10"); rd(4'h7, 8'h77, "R10");
    rd(4'h4, 8'h00, "R10"); rd(4'h5, 8'h00, "R10");
    // R11 latched word read
    wr(4'h2, 8'h0A); rd(4'h4, 8'h11, "R11");
    wr(4'h2, 8'h08); wr(4'h5, 8'hCC);
    wr(4'h2, 8'h0A); rd(4'h5, 8'hBB, "R11 latched");
    rd(4'h4, 8'h11, "R11"); rd(4'h5, 8'hCC, "R11 relatched");
    // R12 auto-increment burst across memory wrap (R8)
    wr(4'h2, 8'h3F);
    wr(4'h4, 8'hA0); wr(4'h5, 8'hA1); wr(4'h6, 8'hA2); wr(4'h7, 8'hA3);
    rd(4'h2, 8'h43, "R12");
    wr(4'h4, 8'hB0); wr(4'h5, 8'hB1); wr(4'h6, 8'hB2); wr(4'h7, 8'hB3);
    rd(4'h2, 8'h47, "R12");
    wr(4'h2, 8'h3F);
    rd(4'h4, 8'hA0, "R12"); rd(4'h5, 8'hA1, "R12"); rd(4'h6, 8'hA2, "R12");
    rd(4'h7, 8'hA3, "R12");
    rd(4'h4, 8'hB0, "R8 wrap"); rd(4'h5, 8'hB1, "R8 wrap"); rd(4'h6, 8'hB2, "R8 wrap");
    rd(4'h7, 8'hB3, "R8 wrap"); rd(4'h2, 8'h47, "R12");
    // R12 16-bit rollover
    wr(4'h2, 8'hFF); wr(4'h3, 8'hFF); rd(4'h7, 8'hB3, "R12");
    rd(4'h2, 8'h03, "R12 rollover"); rd(4'h3, 8'h00, "R12 rollover");
    // R13 unused offsets
    wr(4'hC, 8'hFF); wr(4'hF, 8'hFF);
    rd(4'hC, 8'h00, "R13"); rd(4'hF, 8'h00, "R13"); rd(4'h0, 8'h5A, "R13");
    rd(4'hA, 8'h00, "R13"); rd(4'hB, 8'h80, "R13");
    idle(); idle();
    if (sb.size() != 0) begin
      errs++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

endmodule